// File: doc/BRIEF.md
# Three-Channel Edge-Selectable Up-Counter

This block has three independent up-counters. A small word-addressed register port controls them. Each channel works in one of two modes. In timer mode it adds one on every clock while it runs. In counter mode it adds one whenever a selected edge occurs on any of three shared external inputs. Each input has a separate rising-edge select and falling-edge select for each channel. Each counter climbs toward its own limit value and then returns to zero.

Software changes the mode and edge-select bits in one control word. That word is reached through three addresses: one to read it, one that sets the bits written as one, and one that clears the bits written as one. A separate run word starts and stops channels, and it has the same three addresses. A counter can be read at any moment. A write to a counter only lands while its channel is stopped; while it runs, the write is silently dropped. The external inputs are asynchronous. They are synchronized inside the block before any edge is detected.

Top module: `tri_edge_counter`

Register map, as word addresses on `reg_addr`:

| Address | Name | Access |
|---|---|---|
| 0 | control word | read |
| 1 | control set | write |
| 2 | control clear | write |
| 3 | run word | read |
| 4 | run set | write |
| 5 | run clear | write |
| 6, 7, 8 | count of channel 0, 1, 2 | read and write |
| 9, 10, 11 | limit of channel 0, 1, 2 | read and write |

## Requirements
- R1: After reset, the control word, the run word, every count and every limit read as zero.
- R2: A write to the control-set address (1) ORs the written ones into the control word. A write to the control-clear address (2) clears the bits written as one. Bits written as zero keep their value. A plain write to the control read address (0) changes nothing.
- R3: Control word layout: for channel n (0..2) and input k (0..2), the rising-edge select is bit 6n+2k and the falling-edge select is bit 6n+2k+1. The mode of channel n is bit 29+n, where 1 means counter mode and 0 means timer mode. Bits 28:18 always read as zero.
- R4: A running channel in timer mode adds one on every clock edge.
- R5: A running channel in counter mode adds one on each clock in which at least one of its selected edges is detected. Several selected edges in the same clock add only one. Edges that are not selected, and any edges when no edge is selected at all, leave the count unchanged.
- R6: When the count is at or above the channel's limit and an increment is due, the count becomes zero instead.
- R7: A count write (addresses 6..8) takes effect at the clock edge that carries it, but only while that channel is stopped. While the channel runs, the write is discarded and gives no response. A limit write (addresses 9..11) always takes effect.
- R8: Run bit n is set by writing a one to bit n of the run-set address (4) and cleared by writing a one to bit n of the run-clear address (5). The run word reads back at address 3. A stopped channel holds its count whatever happens on the inputs.
- R9: A read request presents its data on `reg_rdata` after the clock edge that samples the request. The data stays there until the next read.
- R10: A level change on an external input is applied to the count at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | 3 | Asynchronous external inputs shared by all channels |
| reg_en | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
A register write counts at the clock edge that samples it. Read data appears after that same edge, so the bench drives every access at a falling edge and samples `reg_rdata` at the next falling edge. A timer-mode run is bracketed by a run-set write and a run-clear write k cycles apart, which gives exactly k increments; the expected count is that number wrapped modulo the limit plus one. An input edge needs two synchronizer stages and one detect stage. The bench therefore issues back-to-back reads after an input change and expects the old value in the read sampled at the third edge and the new value in the read sampled at the fourth. Every other edge test waits four cycles before reading or stopping the channel.

// File: rtl/tec_pkg.sv
// Package: shared constants for the three-channel edge-selectable counter.
// Assumes a 32-bit register port with word addresses of four bits.
package tec_pkg;
    localparam int NCH       = 3;          // channels
    localparam int NIN       = 3;          // external inputs
    localparam int EPC       = 2 * NIN;    // edge selects per channel
    localparam int MODE_LSB  = 29;         // mode bit of channel 0
    localparam int DW        = 32;         // register data width
    localparam int AW        = 4;          // register address width
    localparam int SEL_BITS  = NCH * EPC;  // number of edge-select bits

    localparam logic [DW-1:0] CTL_MASK =
        (DW'(1) << SEL_BITS) - DW'(1) | (DW'((1 << NCH) - 1) << MODE_LSB);

    localparam logic [AW-1:0] A_CTL     = 4'd0;
    localparam logic [AW-1:0] A_CTL_SET = 4'd1;
    localparam logic [AW-1:0] A_CTL_CLR = 4'd2;
    localparam logic [AW-1:0] A_RUN     = 4'd3;
    localparam logic [AW-1:0] A_RUN_SET = 4'd4;
    localparam logic [AW-1:0] A_RUN_CLR = 4'd5;
    localparam logic [AW-1:0] A_CNT0    = 4'd6;
    localparam logic [AW-1:0] A_PER0    = 4'd9;
endpackage

// File: rtl/tec_sync_edge.sv
// Module: synchronizes the asynchronous external inputs and flags one-cycle
// rising and falling pulses per input. The inputs are sampled by a chain of
// SYNC_STAGES flops. One more flop keeps the previous synchronized level.
// Assumes that each input stays stable for at least two clocks per level.
module tec_sync_edge #(
    parameter int NI          = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] async_in,
    output logic [NI-1:0] rise,
    output logic [NI-1:0] fall
);
    localparam int CHAIN = SYNC_STAGES + 1;

    for (genvar k = 0; k < NI; k++) begin : g_in
        logic [CHAIN-1:0] chain_q;

        // Shift the input level through the synchronizer and history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[CHAIN-2:0], async_in[k]};
        end

        assign rise[k] =  chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
        assign fall[k] = ~chain_q[CHAIN-2] &  chain_q[CHAIN-1];
    end
endmodule

// File: rtl/tec_channel.sv
// Module: one up-counter channel. It steps every clock in timer mode, or on
// any selected detected edge in counter mode, and only while it runs. When an
// increment is due at or above the limit, the count returns to zero. A load
// is accepted only while the channel is stopped.
// Assumes that the edge pulses are single-cycle, from tec_sync_edge.
module tec_channel
    import tec_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           mode,
    input  logic [EPC-1:0] edge_sel,
    input  logic [NIN-1:0] rise,
    input  logic [NIN-1:0] fall,
    input  logic [CW-1:0]  limit,
    input  logic           load,
    input  logic [CW-1:0]  load_val,
    output logic [CW-1:0]  count,
    output logic           step
);
    logic [EPC-1:0] evt;
    logic           hit;

    for (genvar k = 0; k < NIN; k++) begin : g_evt
        assign evt[2*k]   = rise[k];
        assign evt[2*k+1] = fall[k];
    end

    // Any selected edge in this cycle produces a single increment request.
    always_comb begin
        hit  = |(evt & edge_sel);
        step = run & (mode ? hit : 1'b1);
    end

    // Count register: load when stopped, else step with wrap at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load && !run) begin
            count <= load_val;
        end else if (step) begin
            count <= (count >= limit) ? '0 : count + CW'(1);
        end
    end
endmodule

// File: rtl/tec_regs.sv
// Module: register file and decode. It holds the control word, the run word
// and the per-channel limits. It produces the count-load strobes and a
// registered read data path.
// Assumes at most one access per cycle and CW <= DW.
module tec_regs
    import tec_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_en,
    input  logic                    reg_wr,
    input  logic [AW-1:0]           reg_addr,
    input  logic [DW-1:0]           reg_wdata,
    input  logic [NCH-1:0][CW-1:0]  cnt_val,
    output logic [DW-1:0]           ctl_q,
    output logic [NCH-1:0]          run_q,
    output logic [NCH-1:0][CW-1:0]  per_q,
    output logic [NCH-1:0]          cnt_wr,
    output logic [DW-1:0]           reg_rdata
);
    logic          wr_acc;
    logic          rd_acc;
    logic [DW-1:0] rd_next;

    // Decode the access type.
    always_comb begin
        wr_acc = reg_en &  reg_wr;
        rd_acc = reg_en & ~reg_wr;
    end

    // Control word: changed only through the set and clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)                                ctl_q <= '0;
        else if (wr_acc && reg_addr == A_CTL_SET)  ctl_q <= ctl_q | (reg_wdata & CTL_MASK);
        else if (wr_acc && reg_addr == A_CTL_CLR)  ctl_q <= ctl_q & ~reg_wdata;
    end

    // Run word: changed only through the run set and clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)                                run_q <= '0;
        else if (wr_acc && reg_addr == A_RUN_SET)  run_q <= run_q | reg_wdata[NCH-1:0];
        else if (wr_acc && reg_addr == A_RUN_CLR)  run_q <= run_q & ~reg_wdata[NCH-1:0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Limit register of channel i, writable at any time.
        always_ff @(posedge clk) begin
            if (!rst_n)
                per_q[i] <= '0;
            else if (wr_acc && reg_addr == A_PER0 + AW'(i))
                per_q[i] <= reg_wdata[CW-1:0];
        end

        assign cnt_wr[i] = wr_acc && (reg_addr == A_CNT0 + AW'(i));
    end

    // Select the readable value for the current address.
    always_comb begin
        rd_next = '0;
        if (reg_addr == A_CTL) rd_next = ctl_q;
        if (reg_addr == A_RUN) rd_next = DW'(run_q);
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == A_CNT0 + AW'(i)) rd_next = DW'(cnt_val[i]);
            if (reg_addr == A_PER0 + AW'(i)) rd_next = DW'(per_q[i]);
        end
    end

    // Read data register, loaded on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (rd_acc) reg_rdata <= rd_next;
    end
endmodule

// File: rtl/tri_edge_counter.sv
// Module: top of the three-channel edge-selectable up-counter. It joins the
// input synchronizer, the register file and one counter per channel.
// Assumes a single clock domain and a synchronous active-low reset.
module tri_edge_counter
    import tec_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] ext_in,
    input  logic           reg_en,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata
);
    logic [NIN-1:0]         rise;
    logic [NIN-1:0]         fall;
    logic [DW-1:0]          ctl_q;
    logic [NCH-1:0]         run_q;
    logic [NCH-1:0][CW-1:0] per_q;
    logic [NCH-1:0][CW-1:0] cnt_q;
    logic [NCH-1:0]         cnt_wr;
    logic [NCH-1:0]         step;

    tec_sync_edge #(.NI(NIN), .SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in),
        .rise     (rise),
        .fall     (fall)
    );

    tec_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cnt_val   (cnt_q),
        .ctl_q     (ctl_q),
        .run_q     (run_q),
        .per_q     (per_q),
        .cnt_wr    (cnt_wr),
        .reg_rdata (reg_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tec_channel #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[i]),
            .mode     (ctl_q[MODE_LSB + i]),
            .edge_sel (ctl_q[EPC*i +: EPC]),
            .rise     (rise),
            .fall     (fall),
            .limit    (per_q[i]),
            .load     (cnt_wr[i]),
            .load_val (reg_wdata[CW-1:0]),
            .count    (cnt_q[i]),
            .step     (step[i])
        );
    end
endmodule

// File: rtl/tec_checker.sv
// Module: property checker for tri_edge_counter, attached through bind.
// Assumes the internal signal names of the top module.
module tec_checker
    import tec_pkg::*;
#(
    parameter int CW = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_en,
    input logic                   reg_wr,
    input logic [AW-1:0]          reg_addr,
    input logic [DW-1:0]          reg_wdata,
    input logic [DW-1:0]          reg_rdata,
    input logic [DW-1:0]          ctl_q,
    input logic [NCH-1:0]         run_q,
    input logic [NCH-1:0][CW-1:0] per_q,
    input logic [NCH-1:0][CW-1:0] cnt_q,
    input logic [NCH-1:0]         cnt_wr,
    input logic [NCH-1:0]         step
);
    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_wr && reg_addr == A_CTL) |=> (reg_rdata[28:18] == '0));

    assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_wr && reg_addr == A_CTL_SET)
        |=> ((ctl_q & $past(reg_wdata) & CTL_MASK) == ($past(reg_wdata) & CTL_MASK)));

    assert_clear_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_wr && reg_addr == A_CTL_CLR) |=> ((ctl_q & $past(reg_wdata)) == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_stopped_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[i] && !cnt_wr[i]) |=> $stable(cnt_q[i]));

        assert_no_step_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q[i] && !step[i]) |=> $stable(cnt_q[i]));

        assert_timer_increments_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q[i] && !ctl_q[MODE_LSB + i] && cnt_q[i] < per_q[i])
            |=> (cnt_q[i] == CW'($past(cnt_q[i]) + CW'(1))));

        assert_wraps_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (step[i] && cnt_q[i] >= per_q[i]) |=> (cnt_q[i] == '0));

        assert_edge_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (step[i] && cnt_q[i] < per_q[i])
            |=> (cnt_q[i] == CW'($past(cnt_q[i]) + CW'(1))));
    end
endmodule

bind tri_edge_counter tec_checker #(.CW(CW)) u_tec_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctl_q     (ctl_q),
    .run_q     (run_q),
    .per_q     (per_q),
    .cnt_q     (cnt_q),
    .cnt_wr    (cnt_wr),
    .step      (step)
);

// File: tb/tri_edge_counter_test.sv
// Directed bench for tri_edge_counter. Inputs are driven at falling edges and
// outputs are sampled at falling edges.
module tri_edge_counter_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] A_CTL = 4'd0, A_CSET = 4'd1, A_CCLR = 4'd2;
    localparam logic [3:0] A_RUN = 4'd3, A_RSET = 4'd4, A_RCLR = 4'd5;
    localparam logic [3:0] A_CNT0 = 4'd6, A_CNT1 = 4'd7, A_CNT2 = 4'd8;
    localparam logic [3:0] A_PER0 = 4'd9, A_PER1 = 4'd10, A_PER2 = 4'd11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ext_in = '0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;

    tri_edge_counter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_in    (ext_in),
        .reg_en    (reg_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the access is taken at the next rising edge.
    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Run the given channels for exactly k increments in timer mode.
    task automatic run_cycles(input logic [2:0] ch, input int k);
        reg_write(A_RSET, {29'd0, ch});
        idle(k - 1);
        reg_write(A_RCLR, {29'd0, ch});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        reg_read(A_CTL, d);  check("R1 control", d, 32'h0);
        reg_read(A_RUN, d);  check("R1 run", d, 32'h0);
        reg_read(A_CNT0, d); check("R1 count0", d, 32'h0);
        reg_read(A_CNT2, d); check("R1 count2", d, 32'h0);
        reg_read(A_PER1, d); check("R1 limit1", d, 32'h0);
    endtask

    task automatic t_ctl_alias;
        logic [31:0] d;
        reg_write(A_CSET, 32'hFFFF_FFFF);
        reg_read(A_CTL, d);  check("R3 reserved bits read zero", d, 32'hE003_FFFF);
        reg_write(A_CCLR, 32'h0000_0F0F);
        reg_read(A_CTL, d);  check("R2 clear alias", d, 32'hE003_F0F0);
        reg_write(A_CTL, 32'h0000_0000);
        reg_read(A_CTL, d);  check("R2 write to read address ignored", d, 32'hE003_F0F0);
        reg_write(A_CCLR, 32'hFFFF_FFFF);
        reg_read(A_CTL, d);  check("R2 clear all", d, 32'h0);
    endtask

    task automatic t_timer_wrap;
        logic [31:0] d;
        reg_write(A_PER0, 32'd100);
        run_cycles(3'b001, 7);
        reg_read(A_CNT0, d); check("R4 timer seven steps", d, 32'd7);
        reg_write(A_PER0, 32'd3);
        reg_write(A_CNT0, 32'd0);
        run_cycles(3'b001, 10);
        reg_read(A_CNT0, d); check("R6 wrap after ten steps, limit 3", d, 32'd2);
        reg_write(A_CNT0, 32'd9);
        reg_read(A_CNT0, d); check("R7 stopped write lands", d, 32'd9);
        run_cycles(3'b001, 1);
        reg_read(A_CNT0, d); check("R6 above limit wraps", d, 32'd0);
    endtask

    task automatic t_edges;
        logic [31:0] d;
        logic [31:0] d1, d2;
        reg_write(A_PER1, 32'd1000);
        reg_write(A_CSET, 32'h4000_0040);   // ch1 counter mode, in0 rise
        reg_write(A_RSET, 32'h2);
        ext_in[0] = 1'b1;
        reg_read(A_CNT1, d);
        reg_read(A_CNT1, d);
        reg_read(A_CNT1, d1);
        reg_read(A_CNT1, d2);
        check("R10 not yet at third edge", d1, 32'd0);
        check("R10 applied at third edge", d2, 32'd1);
        idle(2);
        ext_in[0] = 1'b0; idle(4);
        for (int p = 0; p < 2; p++) begin
            ext_in[0] = 1'b1; idle(4);
            ext_in[0] = 1'b0; idle(4);
        end
        reg_read(A_CNT1, d); check("R5 rises only", d, 32'd3);
        reg_write(A_CSET, 32'h0000_0080);   // in0 fall too
        for (int p = 0; p < 2; p++) begin
            ext_in[0] = 1'b1; idle(4);
            ext_in[0] = 1'b0; idle(4);
        end
        reg_read(A_CNT1, d); check("R5 both edges", d, 32'd7);
        reg_write(A_CSET, 32'h0000_0500);   // in1 rise, in2 rise
        ext_in[2:1] = 2'b11; idle(4);
        reg_read(A_CNT1, d); check("R5 simultaneous edges add one", d, 32'd8);
        ext_in[2] = 1'b0; idle(4);
        reg_read(A_CNT1, d); check("R5 unselected fall ignored", d, 32'd8);
        ext_in[1] = 1'b0; idle(4);
        reg_write(A_RCLR, 32'h2);
        ext_in[0] = 1'b1; idle(4);
        ext_in[0] = 1'b0; idle(4);
        reg_read(A_CNT1, d); check("R8 stopped channel holds", d, 32'd8);
    endtask

    task automatic t_mode;
        logic [31:0] d;
        reg_write(A_PER2, 32'd1000);
        reg_write(A_CSET, 32'h8000_0000);   // ch2 counter mode, no selects
        reg_write(A_RSET, 32'h4);
        idle(10);
        reg_read(A_CNT2, d); check("R5 no selects, no count", d, 32'd0);
        reg_read(A_RUN, d);  check("R8 run readback", d, 32'h4);
        reg_write(A_CNT2, 32'd77);
        reg_read(A_CNT2, d); check("R7 write while running dropped", d, 32'd0);
        reg_write(A_RCLR, 32'h4);
        reg_read(A_RUN, d);  check("R8 run cleared", d, 32'h0);
        reg_write(A_CNT2, 32'd77);
        reg_read(A_CNT2, d); check("R7 write while stopped", d, 32'd77);
        reg_write(A_CCLR, 32'h8000_0000);   // back to timer mode
        run_cycles(3'b100, 5);
        reg_read(A_CNT2, d); check("R4 timer mode after mode change", d, 32'd82);
        reg_read(A_PER2, d); check("R9 limit readback", d, 32'd1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl_alias();
        t_timer_wrap();
        t_edges();
        t_mode();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule